// File: doc/BRIEF.md
# Palette Access Port

This block lets a host program a bank of eight colour palettes of 256 entries each. Every entry holds a 9-bit RRRGGGBBB colour and one priority flag. The host sees four byte-wide registers, chosen by a 2-bit select:

- an entry pointer;
- a control register that picks the target palette and turns stepping of the pointer on or off;
- an 8-bit colour port that writes RRRGGGBB and derives the ninth bit;
- a 9-bit colour port that takes two writes in a row.

The same registers return the stored data on reads. Reads are combinational and have no side effects.

The palettes form four pairs: ULA, layer 2, sprites and tilemap. A writer loads a run of entries by setting the pointer once and then streaming colour writes. The pointer steps after each complete colour write. The priority flag is kept only for the layer 2 palettes.

Top module: `pal_port`

## Requirements
- R1: After reset the pointer reads 0x00, the control register reads 0x00 (stepping on, palette 0), and the 9-bit port expects its first byte.
- R2: A write to select 0 (pointer) loads the pointer, and select 0 reads it back.
- R3: A write of d to select 1 (8-bit colour) stores colour bits 8..1 = d and colour bit 0 = d[1] OR d[0], with the priority flag cleared. Reading select 1 returns colour bits 8..1. Reading select 3 returns colour bit 0 in bit 0.
- R4: After a select 1 write the pointer increments, unless control bit 7 is 1, in which case it holds.
- R5: The pointer wraps from 0xFF to 0x00 on increment.
- R6: Control bits 6..4 pick the palette, and each of the eight palettes has its own storage. Bits 5..4 give the layer: 00 ULA, 01 layer 2, 10 sprites, 11 tilemap. Bit 6 picks the second palette of the pair. Control bits 3..0 read as 0.
- R7: The 9-bit colour port (select 3) stores nothing on its first write and only latches RRRGGGBB. The second write stores that byte as colour bits 8..1 and its own bit 0 as colour bit 0.
- R8: On the second select 3 write, bit 7 becomes the priority flag when the palette is a layer 2 palette (bits 5..4 = 01). For any other palette it is stored as 0.
- R9: Reading select 3 returns {priority, 000000, colour bit 0}. No read of any select changes the pointer.
- R10: A write to select 0 or select 1 returns the 9-bit port to its first-byte phase.
- R11: The pointer increments after the second byte of a select 3 sequence, if stepping is enabled. It never increments after the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one per cycle |
| reg_sel_i | input | 2 | Register select: 0 pointer, 1 8-bit colour, 2 control, 3 9-bit colour |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register at the current pointer |

## Verification
A write takes effect at the clock edge that samples the strobe: the pointer, the phase, the control register and the palette entry all update at that edge. Reads are combinational. The bench therefore drives a write at a falling edge and drops the strobe at the next falling edge, after the write has landed. It reads a register by changing the select at a falling edge and sampling one time unit later, with no edge in between. The result of each write can then be checked exactly one cycle after the strobe, and the checks that a read leaves the pointer alone see it with nothing between the read and the check.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int DATA_W = 8;
  localparam int COL_W  = 9;

  typedef enum logic [1:0] {
    SEL_INDEX = 2'd0,
    SEL_RGB8  = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_RGB9  = 2'd3
  } reg_sel_e;

  localparam logic [1:0] LAYER_L2 = 2'b01;

  typedef struct packed {
    logic             prio;
    logic [COL_W-1:0] rgb;
  } pal_entry_t;
endpackage

// File: rtl/pal_regs.sv
module pal_regs
  import pal_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int PSEL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PSEL_W-1:0] psel_o,
  output logic              noinc_o,
  output logic              phase_o,
  output logic              mem_we_o,
  output pal_entry_t        mem_wdata_o
);
  logic [DATA_W-1:0] hold_q;
  logic wr_idx, wr_rgb8, wr_ctrl, wr_rgb9, is_l2, step;

  assign wr_idx  = wr_en_i && (reg_sel_i == SEL_INDEX);
  assign wr_rgb8 = wr_en_i && (reg_sel_i == SEL_RGB8);
  assign wr_ctrl = wr_en_i && (reg_sel_i == SEL_CTRL);
  assign wr_rgb9 = wr_en_i && (reg_sel_i == SEL_RGB9);
  assign is_l2   = (psel_o[1:0] == LAYER_L2);
  assign step    = !noinc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o   <= '0;
      psel_o  <= '0;
      noinc_o <= 1'b0;
      phase_o <= 1'b0;
      hold_q  <= '0;
    end else begin
      if (wr_idx) begin
        idx_o   <= wdata_i[IDX_W-1:0];
        phase_o <= 1'b0;
      end
      if (wr_ctrl) begin
        noinc_o <= wdata_i[7];
        psel_o  <= wdata_i[4 +: PSEL_W];
      end
      if (wr_rgb8) begin
        phase_o <= 1'b0;
        if (step) idx_o <= idx_o + IDX_W'(1);
      end
      if (wr_rgb9) begin
        if (!phase_o) begin
          hold_q  <= wdata_i;
          phase_o <= 1'b1;
        end else begin
          phase_o <= 1'b0;
          if (step) idx_o <= idx_o + IDX_W'(1);
        end
      end
    end
  end

  always_comb begin
    mem_we_o    = wr_rgb8 || (wr_rgb9 && phase_o);
    mem_wdata_o = '0;
    if (wr_rgb8) begin
      mem_wdata_o.rgb = {wdata_i, |wdata_i[1:0]};
    end else begin
      mem_wdata_o.prio = is_l2 && wdata_i[7];
      mem_wdata_o.rgb  = {hold_q, wdata_i[0]};
    end
  end
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  pal_entry_t        wdata_i,
  output pal_entry_t        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  pal_entry_t mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/pal_rdmux.sv
module pal_rdmux
  import pal_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int PSEL_W = 3
) (
  input  logic [1:0]        reg_sel_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [PSEL_W-1:0] psel_i,
  input  logic              noinc_i,
  input  pal_entry_t        entry_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int CTRL_PAD = DATA_W - 1 - PSEL_W;
  localparam int RGB9_PAD = DATA_W - 2;

  always_comb begin
    unique case (reg_sel_i)
      SEL_INDEX: rdata_o = DATA_W'(idx_i);
      SEL_RGB8:  rdata_o = entry_i.rgb[COL_W-1:1];
      SEL_CTRL:  rdata_o = {noinc_i, psel_i, {CTRL_PAD{1'b0}}};
      default:   rdata_o = {entry_i.prio, {RGB9_PAD{1'b0}}, entry_i.rgb[0]};
    endcase
  end
endmodule

// File: rtl/pal_port.sv
module pal_port
  import pal_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int PSEL_W = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] reg_sel_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  localparam int ADDR_W = IDX_W + PSEL_W;

  logic [IDX_W-1:0]  idx;
  logic [PSEL_W-1:0] psel;
  logic              noinc;
  logic              phase;
  logic              mem_we;
  pal_entry_t        mem_wdata;
  pal_entry_t        mem_rdata;

  pal_regs #(.IDX_W(IDX_W), .PSEL_W(PSEL_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .reg_sel_i   (reg_sel_i),
    .wdata_i     (wdata_i),
    .idx_o       (idx),
    .psel_o      (psel),
    .noinc_o     (noinc),
    .phase_o     (phase),
    .mem_we_o    (mem_we),
    .mem_wdata_o (mem_wdata)
  );

  pal_store #(.ADDR_W(ADDR_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .addr_i  ({psel, idx}),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );

  pal_rdmux #(.IDX_W(IDX_W), .PSEL_W(PSEL_W)) u_rdmux (
    .reg_sel_i (reg_sel_i),
    .idx_i     (idx),
    .psel_i    (psel),
    .noinc_i   (noinc),
    .entry_i   (mem_rdata),
    .rdata_o   (rdata_o)
  );
endmodule

// File: rtl/pal_port_chk.sv
module pal_port_chk
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       reg_sel_i,
  input logic [7:0]       wdata_i,
  input logic [IDX_W-1:0] idx,
  input logic             noinc,
  input logic             phase
);
  AST_IDX_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(idx)); // R9

  AST_IDX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reg_sel_i == SEL_INDEX) |=> (idx == $past(wdata_i[IDX_W-1:0]))); // R2

  AST_RGB8_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reg_sel_i == SEL_RGB8 && !noinc) |=> (idx == IDX_W'($past(idx) + IDX_W'(1)))); // R4

  AST_RGB8_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reg_sel_i == SEL_RGB8 && noinc) |=> $stable(idx)); // R4

  AST_FIRST_BYTE_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reg_sel_i == SEL_RGB9 && !phase) |=> ($stable(idx) && phase)); // R11

  AST_PHASE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (reg_sel_i == SEL_RGB8 || reg_sel_i == SEL_INDEX)) |=> !phase); // R10
endmodule

bind pal_port pal_port_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .reg_sel_i (reg_sel_i),
  .wdata_i   (wdata_i),
  .idx       (idx),
  .noinc     (noinc),
  .phase     (phase)
);

// File: tb/tb_pal_port.sv
module tb_pal_port;
  localparam time CLK_PERIOD = 10;
  localparam logic [1:0] S_IDX = 2'd0, S_C8 = 2'd1, S_CTL = 2'd2, S_C9 = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  int n_chk = 0;
  int n_fail = 0;

  pal_port dut (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en),
    .reg_sel_i (reg_sel), .wdata_i (wdata), .rdata_o (rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input string req, input logic [1:0] s, input logic [7:0] exp);
    reg_sel = s;
    #1;
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s sel=%0d got=%02h exp=%02h", req, s, rdata, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 pointer", S_IDX, 8'h00);
    chk("R1 control", S_CTL, 8'h00);
    wr(S_IDX, 8'h01);
    wr(S_C9, 8'hC3);
    wr(S_C9, 8'h01);
    wr(S_IDX, 8'h01);
    chk("R1 first phase", S_C8, 8'hC3);
  endtask

  task automatic t_index();
    wr(S_IDX, 8'h5A);
    chk("R2 readback", S_IDX, 8'h5A);
  endtask

  task automatic t_rgb8();
    wr(S_CTL, 8'h00);
    wr(S_IDX, 8'h10);
    wr(S_C8, 8'hE1);
    chk("R4 step", S_IDX, 8'h11);
    wr(S_IDX, 8'h10);
    chk("R3 high bits", S_C8, 8'hE1);
    chk("R3 lsb or", S_C9, 8'h01);
    wr(S_IDX, 8'h20);
    wr(S_C8, 8'h02);
    wr(S_C8, 8'hFC);
    wr(S_IDX, 8'h20);
    chk("R3 lsb from b1", S_C9, 8'h01);
    wr(S_IDX, 8'h21);
    chk("R3 lsb zero", S_C9, 8'h00);
    chk("R6 ctrl low bits", S_CTL, 8'h00);
  endtask

  task automatic t_noinc();
    wr(S_CTL, 8'h80);
    chk("R4 ctrl readback", S_CTL, 8'h80);
    wr(S_IDX, 8'h30);
    wr(S_C8, 8'h44);
    chk("R4 no step", S_IDX, 8'h30);
    chk("R4 stored", S_C8, 8'h44);
  endtask

  task automatic t_wrap();
    wr(S_CTL, 8'h00);
    wr(S_IDX, 8'hFF);
    wr(S_C8, 8'h12);
    chk("R5 wrap", S_IDX, 8'h00);
    wr(S_IDX, 8'hFF);
    chk("R5 entry", S_C8, 8'h12);
  endtask

  task automatic t_nine();
    wr(S_CTL, 8'h20);
    wr(S_IDX, 8'h40);
    wr(S_C9, 8'hA5);
    chk("R11 no step first", S_IDX, 8'h40);
    wr(S_C9, 8'h81);
    chk("R11 step second", S_IDX, 8'h41);
    wr(S_IDX, 8'h40);
    chk("R7 high bits", S_C8, 8'hA5);
    chk("R8 no prio sprite", S_C9, 8'h01);
    chk("R9 read no step", S_IDX, 8'h40);
  endtask

  task automatic t_prio();
    wr(S_CTL, 8'h10);
    wr(S_IDX, 8'h50);
    wr(S_C9, 8'h3C);
    wr(S_C9, 8'h80);
    wr(S_IDX, 8'h50);
    chk("R8 prio l2", S_C9, 8'h80);
    chk("R7 l2 high", S_C8, 8'h3C);
    wr(S_CTL, 8'h50);
    wr(S_C9, 8'h11);
    wr(S_C9, 8'h81);
    wr(S_IDX, 8'h50);
    chk("R8 prio l2 second", S_C9, 8'h81);
    wr(S_CTL, 8'h10);
    chk("R6 l2 pair separate", S_C9, 8'h80);
    chk("R6 l2 pair high", S_C8, 8'h3C);
  endtask

  task automatic t_palsel();
    wr(S_CTL, 8'h00);
    wr(S_IDX, 8'h60);
    wr(S_C8, 8'h11);
    wr(S_CTL, 8'h40);
    wr(S_IDX, 8'h60);
    wr(S_C8, 8'h22);
    wr(S_CTL, 8'h00);
    wr(S_IDX, 8'h60);
    chk("R6 ula first", S_C8, 8'h11);
    wr(S_CTL, 8'h40);
    chk("R6 ula second", S_C8, 8'h22);
  endtask

  task automatic t_phase_reset();
    wr(S_CTL, 8'h30);
    wr(S_IDX, 8'h70);
    wr(S_C9, 8'h55);
    wr(S_IDX, 8'h70);
    wr(S_C9, 8'h66);
    chk("R10 pointer after restart", S_IDX, 8'h70);
    wr(S_C9, 8'h01);
    chk("R10 step", S_IDX, 8'h71);
    wr(S_IDX, 8'h70);
    chk("R10 index restart", S_C8, 8'h66);
    wr(S_IDX, 8'h72);
    wr(S_C9, 8'h77);
    wr(S_C8, 8'h99);
    wr(S_C9, 8'h88);
    wr(S_C9, 8'h00);
    chk("R10 rgb8 restart ptr", S_IDX, 8'h74);
    wr(S_IDX, 8'h73);
    chk("R10 rgb8 restart", S_C8, 8'h88);
    wr(S_IDX, 8'h72);
    chk("R10 rgb8 entry", S_C8, 8'h99);
  endtask

  task automatic t_noinc9();
    wr(S_CTL, 8'h90);
    wr(S_IDX, 8'h80);
    wr(S_C9, 8'h12);
    wr(S_C9, 8'h01);
    chk("R11 hold", S_IDX, 8'h80);
    chk("R11 stored", S_C9, 8'h01);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_index();
    t_rgb8();
    t_noinc();
    t_wrap();
    t_nine();
    t_prio();
    t_palsel();
    t_phase_reset();
    t_noinc9();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule